// File: doc/BRIEF.md
# Configuration Access Window

This block sits between a host-side access port and the requester that builds PCIe configuration requests. It holds a programmable window that is 256 MB wide and aligned to 256 MB. A host access whose address falls inside that window is split into bus number, device/function number and register offset. The block then decides whether the access may go out as a configuration request or must be answered on the spot. Accesses that are refused never reach the link. A refused read returns all-ones data, and a refused write is dropped.

Software reaches a small register set through a plain register port. That port holds a presence indication, an enable bit, a size field that sets the highest reachable bus, and the 64-bit window base. Window accesses use valid/ready handshakes on three channels: the host request, the host response and the outgoing configuration request. The completion return also uses valid/ready. A producer that raises valid must hold it and its payload steady until ready is seen at a clock edge. The block holds its own valid outputs in the same way. Only one access is in flight at a time, so the host port stays not-ready from acceptance until its response is taken.

Top module: `ecam_cfg_window`

## Requirements
- R1: After reset, register index 0 (identity) reads 1 in bit 0. Index 1 (control) reads 0x000C0000: the enable bit (bit 0) is clear and the size field (bits 20:16) is 12. Index 2 (base low) reads 0. No request or response is pending, and the host port is ready.
- R2: While control bit 0 is clear, every host access is answered locally and no configuration request is issued.
- R3: Control bits 20:16 give the last reachable bus number. An access to a bus above it is refused.
- R4: The window base is set through index 2 (address bits 31:0) and index 3 (address bits 63:32). Bits 27:0 of index 2 always read zero. An address is in the window when its bits 63:28 equal the base. Any other address is answered locally.
- R5: A forwarded access carries bus = offset bits 27:20, devfn = offset bits 19:12 and register = offset bits 11:0, where the offset is the address minus the base. It also carries its write flag, write data and byte enables unchanged.
- R6: On bus 0 (the root bus), only devfn 0 is forwarded. Any nonzero devfn is refused.
- R7: An access to a bus other than 0 is forwarded only if link_up is high in the cycle the host access is accepted.
- R8: A refused access is completed with r_local = 1. If it is a read, it returns 0xFFFFFFFF.
- R9: A configuration request holds its payload until c_ready is seen. The host response of a forwarded access appears only after a completion has been accepted. A forwarded read returns the completion data, and a forwarded write returns 0 with r_local = 0. h_ready stays low while an access is in flight.
- R10: A host response stays valid, with its data steady, until r_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index: 0 identity, 1 control, 2 base low, 3 base high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| link_up | input | 1 | Link is up; gates accesses to buses other than 0 |
| h_valid | input | 1 | Host access valid |
| h_ready | output | 1 | Host access accepted when high together with h_valid |
| h_we | input | 1 | Host access is a write |
| h_addr | input | 64 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Host byte enables |
| r_valid | output | 1 | Host response valid |
| r_ready | input | 1 | Host takes the response |
| r_data | output | 32 | Response read data |
| r_local | output | 1 | Response was produced locally (access refused) |
| c_valid | output | 1 | Configuration request valid |
| c_ready | input | 1 | Request taken by the requester |
| c_we | output | 1 | Request is a write |
| c_bus | output | 8 | Target bus number |
| c_devfn | output | 8 | Target device/function |
| c_ofs | output | 12 | Register byte offset |
| c_wdata | output | 32 | Write data |
| c_be | output | 4 | Byte enables |
| cpl_valid | input | 1 | Completion valid |
| cpl_ready | output | 1 | Block is waiting for a completion |
| cpl_data | input | 32 | Completion read data |

## Verification
A wrong filtering decision appears at the ports on the very next cycle after acceptance. It shows as either a configuration request that should not exist or a local all-ones response that should have been a request. The test table therefore checks both channels for every access. A sequencer state that leaks shows as h_ready high during an access, or as a request or response valid that drops before its ready. These are sampled on every stalled cycle. A register that is corrupted shows up only on later accesses, through a shifted bus limit or a missed window. Both are probed right after the register changes.

// File: rtl/ecam_pkg.sv
`timescale 1ns/1ps
package ecam_pkg;
  localparam int BUS_W    = 8;
  localparam int DEVFN_W  = 8;
  localparam int OFS_W    = 12;
  localparam int WIN_W    = BUS_W + DEVFN_W + OFS_W;
  localparam int SIZE_W   = 5;
  localparam int SIZE_LSB = 16;
  localparam int EN_BIT   = 0;
  localparam logic [SIZE_W-1:0] SIZE_RST = 5'd12;

  localparam logic [1:0] IDX_ID   = 2'd0;
  localparam logic [1:0] IDX_CTRL = 2'd1;
  localparam logic [1:0] IDX_BLO  = 2'd2;
  localparam logic [1:0] IDX_BHI  = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} seq_state_t;

  typedef struct packed {
    logic [BUS_W-1:0]   bus;
    logic [DEVFN_W-1:0] devfn;
    logic [OFS_W-1:0]   ofs;
  } cfg_loc_t;
endpackage

// File: rtl/ecam_win_regs.sv
`timescale 1ns/1ps
module ecam_win_regs
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [1:0]              reg_idx,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic                    win_en,
  output logic [SIZE_W-1:0]       last_bus,
  output logic [ADDR_W-1:WIN_W]   win_base
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam int LO_W = DATA_W - WIN_W;

  logic              en_q;
  logic [SIZE_W-1:0] size_q;
  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      size_q <= SIZE_RST;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (reg_we) begin
      case (reg_idx)
        IDX_CTRL: begin
          en_q   <= reg_wdata[EN_BIT];
          size_q <= reg_wdata[SIZE_LSB +: SIZE_W];
        end
        IDX_BLO: lo_q <= reg_wdata[DATA_W-1:WIN_W];
        IDX_BHI: hi_q <= reg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_ID:   reg_rdata[0] = 1'b1;
      IDX_CTRL: begin
        reg_rdata[EN_BIT]              = en_q;
        reg_rdata[SIZE_LSB +: SIZE_W]  = size_q;
      end
      IDX_BLO:  reg_rdata[DATA_W-1:WIN_W] = lo_q;
      default:  reg_rdata[HI_W-1:0] = hi_q;
    endcase
  end

  assign win_en   = en_q;
  assign last_bus = size_q;
  assign win_base = {hi_q, lo_q};

  // R3: bus limit changes only through a register write
  a_r3_size_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(last_bus));
  // R4: window base changes only through a register write
  a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(win_base));
endmodule

// File: rtl/ecam_win_decode.sv
`timescale 1ns/1ps
module ecam_win_decode
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                  win_en,
  input  logic [ADDR_W-1:WIN_W] win_base,
  input  logic [SIZE_W-1:0]     last_bus,
  input  logic                  link_up,
  input  logic [ADDR_W-1:0]     addr,
  output cfg_loc_t              loc,
  output logic                  fwd_ok
);
  logic hit, root, bus_ok, dev_ok;
  logic [BUS_W-1:0] limit;

  assign loc    = cfg_loc_t'(addr[WIN_W-1:0]);
  assign hit    = win_en && (addr[ADDR_W-1:WIN_W] == win_base);
  assign limit  = {{(BUS_W-SIZE_W){1'b0}}, last_bus};
  assign root   = (loc.bus == '0);
  assign bus_ok = (loc.bus <= limit);
  assign dev_ok = root ? (loc.devfn == '0) : link_up;
  assign fwd_ok = hit && bus_ok && dev_ok;
endmodule

// File: rtl/ecam_win_seq.sv
`timescale 1ns/1ps
module ecam_win_seq
  import ecam_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_we,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [BE_W-1:0]   h_be,
  input  cfg_loc_t          loc,
  input  logic              fwd_ok,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [DATA_W-1:0] r_data,
  output logic              r_local,
  output logic              c_valid,
  input  logic              c_ready,
  output logic              c_we,
  output cfg_loc_t          c_loc,
  output logic [DATA_W-1:0] c_wdata,
  output logic [BE_W-1:0]   c_be,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [DATA_W-1:0] cpl_data
);
  seq_state_t        st;
  cfg_loc_t          loc_q;
  logic              we_q, local_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [BE_W-1:0]   be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      loc_q   <= '0;
      we_q    <= 1'b0;
      local_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      be_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (h_valid) begin
          loc_q   <= loc;
          we_q    <= h_we;
          wdata_q <= h_wdata;
          be_q    <= h_be;
          local_q <= !fwd_ok;
          rdata_q <= '1;
          st      <= fwd_ok ? ST_ISSUE : ST_RESP;
        end
        ST_ISSUE: if (c_ready) st <= ST_WAIT;
        ST_WAIT: if (cpl_valid) begin
          rdata_q <= we_q ? '0 : cpl_data;
          st      <= ST_RESP;
        end
        default: if (r_ready) st <= ST_IDLE;
      endcase
    end
  end

  assign h_ready   = (st == ST_IDLE);
  assign c_valid   = (st == ST_ISSUE);
  assign cpl_ready = (st == ST_WAIT);
  assign r_valid   = (st == ST_RESP);
  assign r_data    = rdata_q;
  assign r_local   = local_q;
  assign c_we      = we_q;
  assign c_loc     = loc_q;
  assign c_wdata   = wdata_q;
  assign c_be      = be_q;

  // R9: a stalled request keeps valid and payload
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && !c_ready |=> c_valid && $stable(c_loc) && $stable(c_wdata) && $stable(c_be));
  // R9: a forwarded response follows an accepted completion
  a_r9_resp_after_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_valid) && !r_local |-> $past(cpl_valid && cpl_ready));
  // R10: response held until taken
  a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && !r_ready |=> r_valid && $stable(r_data) && $stable(r_local));
  // R8: a refused read answers all-ones
  a_r8_local_ones: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && r_local && !we_q |-> r_data == '1);
endmodule

// File: rtl/ecam_cfg_window.sv
`timescale 1ns/1ps
module ecam_cfg_window
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              link_up,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [BE_W-1:0]   h_be,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [DATA_W-1:0] r_data,
  output logic              r_local,
  output logic              c_valid,
  input  logic              c_ready,
  output logic              c_we,
  output logic [BUS_W-1:0]  c_bus,
  output logic [DEVFN_W-1:0] c_devfn,
  output logic [OFS_W-1:0]  c_ofs,
  output logic [DATA_W-1:0] c_wdata,
  output logic [BE_W-1:0]   c_be,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [DATA_W-1:0] cpl_data
);
  logic                  win_en;
  logic [SIZE_W-1:0]     last_bus;
  logic [ADDR_W-1:WIN_W] win_base;
  cfg_loc_t              loc, c_loc;
  logic                  fwd_ok;

  ecam_win_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_en(win_en),
    .last_bus(last_bus), .win_base(win_base)
  );

  ecam_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .win_en(win_en), .win_base(win_base), .last_bus(last_bus),
    .link_up(link_up), .addr(h_addr), .loc(loc), .fwd_ok(fwd_ok)
  );

  ecam_win_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_we(h_we), .h_wdata(h_wdata), .h_be(h_be), .loc(loc), .fwd_ok(fwd_ok),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_local(r_local),
    .c_valid(c_valid), .c_ready(c_ready), .c_we(c_we), .c_loc(c_loc),
    .c_wdata(c_wdata), .c_be(c_be), .cpl_valid(cpl_valid),
    .cpl_ready(cpl_ready), .cpl_data(cpl_data)
  );

  assign c_bus   = c_loc.bus;
  assign c_devfn = c_loc.devfn;
  assign c_ofs   = c_loc.ofs;

  // R6: root bus requests always target devfn 0
  a_r6_root_dev0: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && c_bus == '0 |-> c_devfn == '0);
  // R7: downstream request only if link was up at acceptance
  a_r7_link_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_valid) && c_bus != '0 |-> $past(link_up));
  // R3: request bus within the limit in force at acceptance
  a_r3_bus_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_valid) |-> c_bus <= {{(BUS_W-SIZE_W){1'b0}}, $past(last_bus)});
  // R2: no request rises unless the window was enabled
  a_r2_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_valid) |-> $past(win_en));
endmodule

// File: tb/ecam_cfg_window_tb.sv
`timescale 1ns/1ps
module ecam_cfg_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        link_up = 1'b0;
  logic        h_valid = 1'b0, h_ready, h_we = 1'b0;
  logic [63:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [3:0]  h_be = '0;
  logic        r_valid, r_ready = 1'b0, r_local;
  logic [31:0] r_data;
  logic        c_valid, c_ready = 1'b0, c_we;
  logic [7:0]  c_bus, c_devfn;
  logic [11:0] c_ofs;
  logic [31:0] c_wdata;
  logic [3:0]  c_be;
  logic        cpl_valid = 1'b0, cpl_ready;
  logic [31:0] cpl_data = '0;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ecam_cfg_window u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
    .h_valid(h_valid), .h_ready(h_ready), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_be(h_be), .r_valid(r_valid), .r_ready(r_ready),
    .r_data(r_data), .r_local(r_local), .c_valid(c_valid), .c_ready(c_ready),
    .c_we(c_we), .c_bus(c_bus), .c_devfn(c_devfn), .c_ofs(c_ofs),
    .c_wdata(c_wdata), .c_be(c_be), .cpl_valid(cpl_valid),
    .cpl_ready(cpl_ready), .cpl_data(cpl_data)
  );

  localparam logic [63:0] BASE = 64'h0000_0012_E000_0000;

  // {we, link, offset[27:0], expect_forward}
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd0,   8'h00, 12'h000, 1'b1},
    {1'b0, 1'b1, 8'd0,   8'h01, 12'h000, 1'b0},
    {1'b0, 1'b1, 8'd0,   8'h08, 12'h004, 1'b0},
    {1'b0, 1'b1, 8'd1,   8'h00, 12'h010, 1'b1},
    {1'b0, 1'b0, 8'd1,   8'h00, 12'h010, 1'b0},
    {1'b1, 1'b1, 8'd2,   8'h0A, 12'h3FC, 1'b1},
    {1'b1, 1'b1, 8'd12,  8'h00, 12'h100, 1'b1},
    {1'b0, 1'b1, 8'd13,  8'h00, 12'h000, 1'b0},
    {1'b1, 1'b1, 8'd0,   8'h03, 12'h020, 1'b0},
    {1'b0, 1'b1, 8'hFF,  8'h00, 12'h000, 1'b0},
    {1'b1, 1'b0, 8'd5,   8'h10, 12'h040, 1'b0},
    {1'b0, 1'b1, 8'd0,   8'h00, 12'hFFC, 1'b1}
  };

  logic        t_req, t_local, t_hready, stall_bad;
  logic [7:0]  t_bus, t_devfn;
  logic [11:0] t_ofs;
  logic        t_we;
  logic [31:0] t_wdata, t_rdata;
  logic [3:0]  t_be;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  task automatic do_acc(input logic we, input logic [63:0] addr, input logic [31:0] wd,
                        input logic [3:0] be, input logic [31:0] cd, input int cst, input int rst_cyc);
    int n;
    t_req = 1'b0; stall_bad = 1'b0;
    @(negedge clk);
    h_valid = 1'b1; h_we = we; h_addr = addr; h_wdata = wd; h_be = be;
    n = 0;
    while (!h_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    h_valid = 1'b0;
    t_hready = h_ready;
    if (c_valid) begin
      t_req = 1'b1; t_bus = c_bus; t_devfn = c_devfn; t_ofs = c_ofs;
      t_we = c_we; t_wdata = c_wdata; t_be = c_be;
      for (int i = 0; i < cst; i++) begin
        @(negedge clk);
        if (!c_valid || c_bus != t_bus || c_devfn != t_devfn || c_ofs != t_ofs ||
            c_wdata != t_wdata || h_ready || r_valid) stall_bad = 1'b1;
      end
      c_ready = 1'b1;
      @(negedge clk);
      c_ready = 1'b0;
      if (r_valid) stall_bad = 1'b1;
      cpl_valid = 1'b1; cpl_data = cd;
      @(negedge clk);
      cpl_valid = 1'b0;
    end
    n = 0;
    while (!r_valid && n < 50) begin @(negedge clk); n++; end
    t_rdata = r_data; t_local = r_local;
    for (int i = 0; i < rst_cyc; i++) begin
      @(negedge clk);
      if (!r_valid || r_data != t_rdata || r_local != t_local || h_ready) stall_bad = 1'b1;
    end
    r_ready = 1'b1;
    @(negedge clk);
    r_ready = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] a;
    logic [30:0] v;
    logic [31:0] exp_d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(h_ready && !c_valid && !r_valid, "R1 idle", {h_ready, c_valid, r_valid}, 3'b100);
    reg_rd(2'd0, rd); chk(rd[0] == 1'b1, "R1 identity", rd, 1);
    reg_rd(2'd1, rd); chk(rd == 32'h000C_0000, "R1 control", rd, 32'h000C_0000);
    reg_rd(2'd2, rd); chk(rd == 32'h0, "R1 base low", rd, 0);

    // R4: base programming and alignment
    reg_wr(2'd2, 32'hFFFF_FFFF);
    reg_rd(2'd2, rd); chk(rd == 32'hF000_0000, "R4 base low align", rd, 32'hF000_0000);
    reg_wr(2'd2, BASE[31:0]);
    reg_wr(2'd3, BASE[63:32]);
    reg_rd(2'd3, rd); chk(rd == BASE[63:32], "R4 base high", rd, BASE[63:32]);

    // R2: window disabled, access is local
    link_up = 1'b1;
    do_acc(1'b0, BASE, 32'h0, 4'hF, 32'h1234_5678, 0, 0);
    chk(!t_req && t_local && t_rdata == 32'hFFFF_FFFF, "R2 disabled read", {t_req, t_local, t_rdata}, {2'b01, 32'hFFFF_FFFF});
    do_acc(1'b1, BASE + 64'h0010_0000, 32'h55, 4'hF, 32'h0, 0, 0);
    chk(!t_req && t_local, "R2 disabled write", {t_req, t_local}, 2'b01);

    reg_wr(2'd1, 32'h000C_0001);

    // Table walk: R5, R6, R7, R3, R8, R9
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      link_up = v[29];
      a = BASE + {36'h0, v[28:1]};
      exp_d = 32'hA000_0000 | k;
      do_acc(v[30], a, 32'hC0DE_0000 | k, 4'(k), exp_d, 0, 0);
      chk(t_req == v[0] && t_local == !v[0], "R6 R7 R3 forward decision", {t_req, t_local}, {v[0], !v[0]});
      chk(!t_hready, "R9 busy while in flight", t_hready, 0);
      if (v[0]) begin
        chk(t_bus == v[28:21] && t_devfn == v[20:13] && t_ofs == v[12:1],
            "R5 decode", {t_bus, t_devfn, t_ofs}, v[28:1]);
        chk(t_we == v[30] && t_be == 4'(k) && t_wdata == (32'hC0DE_0000 | k),
            "R5 payload", {t_we, t_be, t_wdata}, {v[30], 4'(k), 32'hC0DE_0000 | k});
        chk(t_rdata == (v[30] ? 32'h0 : exp_d), "R9 response data", t_rdata, v[30] ? 32'h0 : exp_d);
      end else if (!v[30]) begin
        chk(t_rdata == 32'hFFFF_FFFF, "R8 local read ones", t_rdata, 32'hFFFF_FFFF);
      end
    end

    // R4: address outside window is local
    link_up = 1'b1;
    do_acc(1'b0, BASE + 64'h1000_0000, 32'h0, 4'hF, 32'h0, 0, 0);
    chk(!t_req && t_local && t_rdata == 32'hFFFF_FFFF, "R4 outside window", {t_req, t_local}, 2'b01);
    do_acc(1'b0, BASE ^ 64'h0000_0100_0000_0000, 32'h0, 4'hF, 32'h0, 0, 0);
    chk(!t_req && t_local, "R4 high base mismatch", {t_req, t_local}, 2'b01);

    // R3: shrink bus limit to 3
    reg_wr(2'd1, 32'h0003_0001);
    reg_rd(2'd1, rd); chk(rd == 32'h0003_0001, "R3 control readback", rd, 32'h0003_0001);
    do_acc(1'b0, BASE + 64'h0030_0000, 32'h0, 4'hF, 32'h77, 0, 0);
    chk(t_req && t_bus == 8'd3, "R3 last bus forwarded", {t_req, t_bus}, {1'b1, 8'd3});
    do_acc(1'b0, BASE + 64'h0040_0000, 32'h0, 4'hF, 32'h77, 0, 0);
    chk(!t_req && t_local && t_rdata == 32'hFFFF_FFFF, "R3 above limit refused", {t_req, t_local}, 2'b01);

    // R9, R10: back-pressure on request and response
    do_acc(1'b0, BASE + 64'h0020_0008, 32'h0, 4'h3, 32'hBEEF_0001, 3, 2);
    chk(t_req && !stall_bad, "R9 request held under stall", stall_bad, 0);
    chk(t_rdata == 32'hBEEF_0001 && !t_local, "R10 response held", t_rdata, 32'hBEEF_0001);
    do_acc(1'b0, BASE + 64'h0000_1000, 32'h0, 4'hF, 32'h0, 0, 3);
    chk(!stall_bad && t_local && t_rdata == 32'hFFFF_FFFF, "R10 local response held", stall_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule